// File: doc/BRIEF.md
# Aging Priority-Boost Command Scheduler

This block holds a short queue of memory commands and chooses which one goes to the memory controller next. Every command carries a service-class tag, class 1 or class 2, and an identifier. Class 1 normally goes first, and within a class older commands go first. If that were the whole policy, a class-2 command, or any old command, could wait forever behind a steady stream of class-1 traffic.

Three programmable aging timers prevent this. One timer watches class 1, one watches class 2, and one watches the head of the queue. Each timer counts in steps of sixteen clock cycles for as long as it has something to watch. When it reaches its threshold, it grants a one-shot boost that places its target at the front for a single issue. The timer then starts again from zero. Software sets the three thresholds through one 32-bit configuration word.

Commands enter through a push port that has a ready signal. They leave through a valid/ready issue port that reports the identifier and class of the chosen command.

Top module: `prio_age_sched`

## Requirements
- R1: After reset the queue is empty, `iss_valid` is low, `push_ready` is high, and `cfg_rdata` reads 0x00FFFFFF, meaning every threshold is 0xFF.
- R2: In the configuration word, the class-1 threshold occupies bits 23:16, the class-2 threshold bits 15:8 and the queue-head threshold bits 7:0. A write with `cfg_we` high updates all three fields. Bits 31:24 ignore writes and always read as zero.
- R3: The queue holds 8 commands. While it is full, `push_ready` is low, and a push offered during that time is dropped and never issues.
- R4: With no boost active, the oldest class-1 command (`push_cos`=0) issues before any class-2 command (`push_cos`=1). Commands of the same class issue in arrival order.
- R5: A timer grants its boost only after its target has been pending for N×16 consecutive cycles, where N is the timer's threshold field.
- R6: An active class-2 boost makes the oldest class-2 command issue next, even when class-1 commands are waiting.
- R7: An active queue-head boost makes the oldest command in the queue issue next, whatever its class.
- R8: When several boosts are active together, the queue-head boost wins, then the class-1 boost, then the class-2 boost.
- R9: A boost covers exactly one issue. The timer that granted it then restarts from zero, so the next issue follows the normal order unless another boost is active.
- R10: A class timer stays at zero while its class has nothing queued, and the queue-head timer stays at zero while the queue is empty.
- R11: A threshold of 0 disables its timer, which then never grants a boost.
- R12: `iss_valid` is high exactly when the queue holds a command, and a command leaves on a cycle where `iss_valid` and `iss_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | A command is offered for queuing |
| push_ready | output | 1 | The queue can accept a command |
| push_cos | input | 1 | Service class of the offered command: 0 = class 1, 1 = class 2 |
| push_id | input | ID_W | Identifier of the offered command |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| iss_valid | output | 1 | A command is presented for issue |
| iss_ready | input | 1 | The controller accepts the presented command |
| iss_cos | output | 1 | Service class of the presented command |
| iss_id | output | ID_W | Identifier of the presented command |

## Verification
The assertions check on every cycle that the occupancy never exceeds the depth and that a full queue refuses pushes. They also check that an empty queue presents nothing and that occupancy falls by one when an issue happens without a push. Further assertions check that a queue-head boost always takes the head entry, that a class boost never comes from a disabled threshold, and that a granted boost persists until it is used or its threshold changes. The bench scenarios show what no single-cycle property can: the exact issue order under each combination of thresholds, whether a boost arrives before or after N×16 cycles, the one-shot nature of a boost, and a timer that stays idle while its class is absent.

// File: rtl/sched_pkg.sv
package sched_pkg;
   localparam int FIELD_W = 8;

   typedef enum logic [1:0] {
      WIN_NORM = 2'd0,
      WIN_OLD  = 2'd1,
      WIN_C1   = 2'd2,
      WIN_C2   = 2'd3
   } win_e;

   localparam logic COS_ONE = 1'b0;
   localparam logic COS_TWO = 1'b1;
endpackage

// File: rtl/sched_age_timer.sv
module sched_age_timer #(
   parameter int TW  = 8,
   parameter int PRE = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          clr,
   input  logic [TW-1:0] thr,
   output logic          expired
);
   localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;

   initial assert (PRE >= 2 && (PRE & (PRE - 1)) == 0)
      else $error("PRE must be a power of two of at least 2");

   logic [PW-1:0] pre_q;
   logic [TW-1:0] units_q;

   assign expired = (thr != '0) && (units_q >= thr);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || clr) begin
         pre_q   <= '0;
         units_q <= '0;
      end else if (!expired && units_q != '1) begin
         if (pre_q == PW'(PRE - 1)) begin
            pre_q   <= '0;
            units_q <= units_q + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   // R9: a granted boost stays until consumed or the threshold moves
   p_boost_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && expired) |=> (expired || thr != $past(thr)));

   // R11: a zero threshold never yields a boost
   p_zero_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> thr != '0);
endmodule

// File: rtl/sched_queue.sv
module sched_queue #(
   parameter int DEPTH = 8,
   parameter int ID_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_en,
   input  logic                       push_cos,
   input  logic [ID_W-1:0]            push_id,
   input  logic                       pop_en,
   input  logic [$clog2(DEPTH)-1:0]   pop_idx,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic [DEPTH-1:0]           vld_v,
   output logic [DEPTH-1:0]           cos_v,
   output logic [DEPTH-1:0][ID_W-1:0] id_v
);
   localparam int IW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] wr_pos;

   assign wr_pos = count - CW'(pop_en);

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_vld
         assign vld_v[g] = CW'(g) < count;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         cos_v <= '0;
         id_v  <= '0;
      end else begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (pop_en && IW'(i) >= pop_idx) begin
               cos_v[i] <= cos_v[i+1];
               id_v[i]  <= id_v[i+1];
            end
         end
         if (push_en) begin
            cos_v[IW'(wr_pos)] <= push_cos;
            id_v[IW'(wr_pos)]  <= push_id;
         end
         count <= count + CW'(push_en) - CW'(pop_en);
      end
   end

   // R3: occupancy never exceeds the depth
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R12: an issue without a push lowers occupancy by one
   p_pop_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && !push_en) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/sched_pick.sv
module sched_pick
   import sched_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0]         vld_v,
   input  logic [DEPTH-1:0]         cos_v,
   input  logic                     boost_old,
   input  logic                     boost_c1,
   input  logic                     boost_c2,
   output logic                     has_c1,
   output logic                     has_c2,
   output logic [$clog2(DEPTH)-1:0] sel,
   output win_e                     win
);
   localparam int IW = $clog2(DEPTH);

   logic [IW-1:0] idx1, idx2;

   always_comb begin
      has_c1 = 1'b0;
      has_c2 = 1'b0;
      idx1   = '0;
      idx2   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (vld_v[i] && cos_v[i] == COS_ONE) begin
            has_c1 = 1'b1;
            idx1   = IW'(i);
         end
         if (vld_v[i] && cos_v[i] == COS_TWO) begin
            has_c2 = 1'b1;
            idx2   = IW'(i);
         end
      end
   end

   always_comb begin
      sel = '0;
      win = WIN_NORM;
      if (boost_old && vld_v[0]) begin
         win = WIN_OLD;
      end else if (boost_c1 && has_c1) begin
         sel = idx1;
         win = WIN_C1;
      end else if (boost_c2 && has_c2) begin
         sel = idx2;
         win = WIN_C2;
      end else if (has_c1) begin
         sel = idx1;
      end else begin
         sel = idx2;
      end
   end
endmodule

// File: rtl/prio_age_sched.sv
module prio_age_sched
   import sched_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int ID_W  = 4,
   parameter int PRE   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_valid,
   output logic            push_ready,
   input  logic            push_cos,
   input  logic [ID_W-1:0] push_id,
   input  logic            cfg_we,
   input  logic [31:0]     cfg_wdata,
   output logic [31:0]     cfg_rdata,
   output logic            iss_valid,
   input  logic            iss_ready,
   output logic            iss_cos,
   output logic [ID_W-1:0] iss_id
);
   localparam int IW     = $clog2(DEPTH);
   localparam int CW     = $clog2(DEPTH + 1);
   localparam int NTIMER = 3;

   initial assert (DEPTH >= 2 && ID_W >= 1)
      else $error("DEPTH must be at least 2 and ID_W at least 1");

   logic [FIELD_W-1:0] thr_q [NTIMER];
   logic [NTIMER-1:0]  run_v, clr_v, exp_v;
   logic [CW-1:0]          count;
   logic [DEPTH-1:0]       vld_v, cos_v;
   logic [DEPTH-1:0][ID_W-1:0] id_v;
   logic [IW-1:0]          sel;
   win_e                   win;
   logic                   has_c1, has_c2, push_en, fire;

   // timer 0: queue head, timer 1: class 1, timer 2: class 2
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NTIMER; k++) thr_q[k] <= '1;
      end else if (cfg_we) begin
         thr_q[1] <= cfg_wdata[23:16];
         thr_q[2] <= cfg_wdata[15:8];
         thr_q[0] <= cfg_wdata[7:0];
      end
   end

   assign cfg_rdata = {8'h00, thr_q[1], thr_q[2], thr_q[0]};

   assign push_ready = count != CW'(DEPTH);
   assign push_en    = push_valid && push_ready;
   assign iss_valid  = count != '0;
   assign fire       = iss_valid && iss_ready;
   assign iss_cos    = cos_v[sel];
   assign iss_id     = id_v[sel];

   assign run_v = {has_c2, has_c1, iss_valid};
   assign clr_v = {fire && win == WIN_C2, fire && win == WIN_C1,
                   fire && win == WIN_OLD};

   generate
      for (genvar t = 0; t < NTIMER; t++) begin : g_tmr
         sched_age_timer #(.TW(FIELD_W), .PRE(PRE)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_v[t]),
            .clr     (clr_v[t]),
            .thr     (thr_q[t]),
            .expired (exp_v[t])
         );
      end
   endgenerate

   sched_queue #(.DEPTH(DEPTH), .ID_W(ID_W)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (push_en),
      .push_cos (push_cos),
      .push_id  (push_id),
      .pop_en   (fire),
      .pop_idx  (sel),
      .count    (count),
      .vld_v    (vld_v),
      .cos_v    (cos_v),
      .id_v     (id_v)
   );

   sched_pick #(.DEPTH(DEPTH)) u_pick (
      .vld_v     (vld_v),
      .cos_v     (cos_v),
      .boost_old (exp_v[0]),
      .boost_c1  (exp_v[1]),
      .boost_c2  (exp_v[2]),
      .has_c1    (has_c1),
      .has_c2    (has_c2),
      .sel       (sel),
      .win       (win)
   );

   // R3: a full queue refuses pushes
   p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count == CW'(DEPTH) |-> !push_ready);

   // R12: nothing is presented from an empty queue
   p_empty_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      count == '0 |-> !iss_valid);

   // R7: a queue-head boost issues the head entry
   p_old_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && win == WIN_OLD) |-> iss_id == id_v[0]);

   // R11: a class-1 boost never comes from a disabled threshold
   p_c1_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && win == WIN_C1) |-> thr_q[1] != '0);
endmodule

// File: tb/prio_age_sched_bench.sv
module prio_age_sched_bench;
   localparam int ID_W = 4;
   localparam int NV   = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            push_valid = 1'b0;
   logic            push_ready;
   logic            push_cos = 1'b0;
   logic [ID_W-1:0] push_id = '0;
   logic            cfg_we = 1'b0;
   logic [31:0]     cfg_wdata = '0;
   logic [31:0]     cfg_rdata;
   logic            iss_valid;
   logic            iss_ready = 1'b0;
   logic            iss_cos;
   logic [ID_W-1:0] iss_id;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   prio_age_sched #(.DEPTH(8), .ID_W(ID_W), .PRE(16)) u_prio_age_sched (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_ready(push_ready),
      .push_cos(push_cos), .push_id(push_id),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_cos(iss_cos), .iss_id(iss_id)
   );

   // vectors: config word, idle wait, first and second issued IDs
   // fixed push pattern: id1 class2, id2 class1, id3 class2, id4 class1
   localparam logic [31:0] V_CFG  [NV] = '{32'h0000_0000, 32'h0000_0100,
      32'h0001_0101, 32'h0001_0100, 32'h0000_0200, 32'h0000_0200, 32'h0000_0001};
   localparam int          V_WAIT [NV] = '{300, 40, 40, 40, 20, 40, 40};
   localparam logic [3:0]  V_ID_A [NV] = '{4'd2, 4'd1, 4'd1, 4'd2, 4'd2, 4'd1, 4'd1};
   localparam logic [3:0]  V_ID_B [NV] = '{4'd4, 4'd2, 4'd2, 4'd1, 4'd4, 4'd2, 4'd2};
   localparam string       V_REQ  [NV] = '{"R4/R11", "R6/R9", "R7/R8", "R8",
      "R5 early", "R5 late", "R7"};

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [31:0] w);
      cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push(input logic cos, input logic [3:0] id);
      push_valid = 1'b1; push_cos = cos; push_id = id;
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic take(output logic [3:0] id, output bit ok);
      iss_ready = 1'b1;
      ok = iss_valid;
      id = iss_id;
      @(negedge clk);
      iss_ready = 1'b0;
   endtask

   task automatic drain(output int n);
      n = 0;
      iss_ready = 1'b1;
      while (iss_valid) begin
         n++;
         @(negedge clk);
      end
      iss_ready = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [3:0] id;
      bit ok;
      int n;
      bit saw_bad;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(cfg_rdata == 32'h00FF_FFFF, "R1 cfg", cfg_rdata, 32'h00FF_FFFF);
      chk(iss_valid == 1'b0, "R1 valid", iss_valid, 0);
      chk(push_ready == 1'b1, "R1 ready", push_ready, 1);

      // R2: field readback, reserved bits drop writes
      cfg_write(32'hAB12_3456);
      chk(cfg_rdata == 32'h0012_3456, "R2", cfg_rdata, 32'h0012_3456);

      // table walk
      for (int v = 0; v < NV; v++) begin
         cfg_write(V_CFG[v]);
         push(1'b1, 4'd1); push(1'b0, 4'd2); push(1'b1, 4'd3); push(1'b0, 4'd4);
         repeat (V_WAIT[v]) @(negedge clk);
         take(id, ok);
         chk(ok && id == V_ID_A[v], V_REQ[v], id, V_ID_A[v]);
         take(id, ok);
         chk(ok && id == V_ID_B[v], V_REQ[v], id, V_ID_B[v]);
         drain(n);
      end

      // R4: full order with timers disabled
      cfg_write(32'h0);
      push(1'b1, 4'd1); push(1'b0, 4'd2); push(1'b1, 4'd3); push(1'b0, 4'd4);
      take(id, ok); chk(ok && id == 4'd2, "R4 order", id, 2);
      take(id, ok); chk(ok && id == 4'd4, "R4 order", id, 4);
      take(id, ok); chk(ok && id == 4'd1, "R4 order", id, 1);
      take(id, ok); chk(ok && id == 4'd3, "R4 order", id, 3);
      chk(iss_valid == 1'b0, "R12 empty", iss_valid, 0);

      // R3: fill, refuse, drain exactly eight
      for (int i = 0; i < 8; i++) push(i[0], 4'(i));
      chk(push_ready == 1'b0, "R3 full", push_ready, 0);
      push(1'b0, 4'hF);
      saw_bad = 1'b0;
      n = 0;
      iss_ready = 1'b1;
      while (iss_valid) begin
         if (iss_id == 4'hF) saw_bad = 1'b1;
         n++;
         @(negedge clk);
      end
      iss_ready = 1'b0;
      chk(n == 8 && !saw_bad, "R3 drop", n, 8);

      // R10: class-2 timer idle while class 2 absent
      cfg_write(32'h0000_0100);
      push(1'b0, 4'd5); push(1'b0, 4'd6);
      repeat (40) @(negedge clk);
      push(1'b1, 4'd7);
      take(id, ok);
      chk(ok && id == 4'd5, "R10", id, 5);
      drain(n);

      // R12: no issue while ready is low
      push(1'b0, 4'd9);
      repeat (3) @(negedge clk);
      chk(iss_valid && iss_id == 4'd9, "R12 hold", iss_id, 9);
      drain(n);
      chk(n == 1, "R12 one", n, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule